// File: doc/BRIEF.md
# Segmented physical address generator

This block turns a segment:offset pair into a flat 20-bit physical address. It keeps four 16-bit segment base registers, one each for code, data, stack and extra accesses. A requester picks one of them with a 2-bit select and supplies a 16-bit offset. The block multiplies the chosen base by sixteen, adds the offset and keeps only the low 20 bits of the sum.

A fetch unit pairs the code base with its instruction pointer. A load/store path pairs the data or extra base with an effective offset. A stack engine pairs the stack base with its stack pointer. Each register covers a 64 KB window that starts on a 16-byte boundary. Windows may overlap, and many different pairs can name the same byte. The result and its valid flag come from registers, one clock after the request.

Top module: `seg_phys_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all four segment registers become 0000h, `pa_valid` becomes 0 and `pa_addr` becomes 00000h.
- R2: When `req` is high at a clock edge, `pa_addr` after that edge equals (selected segment × 16 + `req_off`) modulo 2^20. For example, 2500h:95F3h gives 2E5F3h, 2500h:0000h gives 25000h and 2500h:FFFFh gives 34FFFh.
- R3: A sum of 100000h or more wraps around and keeps only its low 20 bits. For example, FFFFh:FFFFh gives 0FFEFh and F800h:8000h gives 00000h.
- R4: `req_sel` and `seg_wsel` use the same encoding: 00 = extra, 01 = code, 10 = stack, 11 = data. The four registers hold independent values.
- R5: `pa_valid` is high in exactly the cycle after each cycle in which `req` was high. When no request is made, `pa_addr` holds its last value.
- R6: When a segment write and a request to the same register fall in the same cycle, the address is formed from the value the register held before the write. The new value applies from the next request on.
- R7: A segment write with `seg_we` high loads `seg_wdata` into the selected register only. The other three registers keep their values.
- R8: Different pairs that point at the same byte produce the same address. For example, 1000h:5020h, 1500h:0020h and 1502h:0000h all give 15020h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Register to write (00 extra, 01 code, 10 stack, 11 data) |
| seg_wdata | input | 16 | New segment base value |
| req | input | 1 | Address request strobe |
| req_sel | input | 2 | Segment used by the request (same encoding) |
| req_off | input | 16 | 16-bit offset of the request |
| pa_valid | output | 1 | Registered valid, one cycle after `req` |
| pa_addr | output | 20 | Registered 20-bit physical address |

## Verification
A segment write and an address request can land in the same cycle, and they can target the same register. The bench first loads a known base into the code register. It then drives a write of a new base and a request on that register in one cycle. The address that comes out must be built from the older base. A second request alone must then show the new base, which proves the write was not lost.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int SEG_COUNT = 4;

  typedef enum logic [1:0] {
    SEL_EXTRA = 2'b00,
    SEL_CODE  = 2'b01,
    SEL_STACK = 2'b10,
    SEL_DATA  = 2'b11
  } seg_sel_e;

endpackage

// File: rtl/seg_base_regs.sv
// Bank of segment base registers: one write port, one combinational read port.
module seg_base_regs #(
  parameter int SEG_W   = 16,
  parameter int NUM_SEG = 4,
  localparam int SEL_W  = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [SEG_W-1:0] wdata,
  input  logic [SEL_W-1:0] rsel,
  output logic [SEG_W-1:0] rdata
);

  logic [SEG_W-1:0] base_q [NUM_SEG];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_base
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i] <= '0;
      end else if (we && (wsel == SEL_W'(i))) begin
        base_q[i] <= wdata;
      end
    end

    // R7: a write aimed elsewhere leaves this register untouched
    p_other_stable_r7: assert property (@(posedge clk) disable iff (rst)
      (we && (wsel != SEL_W'(i))) |=> $stable(base_q[i]));
  end

  // Read returns the pre-write value in the cycle of a write (R6)
  assign rdata = base_q[rsel];

  // R7: the written value lands in the selected register
  p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
    we |=> (base_q[$past(wsel)] == $past(wdata)));

endmodule

// File: rtl/seg_offset_adder.sv
// Shift-and-add of base and offset, truncated to the physical width.
module seg_offset_adder #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa
);

  logic [PA_W-1:0] base_ext;
  logic [PA_W-1:0] off_ext;

  always_comb begin
    base_ext = PA_W'({seg, {SHIFT{1'b0}}});
    off_ext  = PA_W'(off);
    pa       = base_ext + off_ext;   // modulo 2^PA_W wrap (R3)
  end

endmodule

// File: rtl/seg_phys_addr_gen.sv
module seg_phys_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  parameter int PA_W    = 20,
  parameter int NUM_SEG = SEG_COUNT,
  localparam int SEL_W  = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seg_we,
  input  logic [SEL_W-1:0] seg_wsel,
  input  logic [SEG_W-1:0] seg_wdata,
  input  logic             req,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [OFF_W-1:0] req_off,
  output logic             pa_valid,
  output logic [PA_W-1:0]  pa_addr
);

  logic [SEG_W-1:0] sel_base;
  logic [PA_W-1:0]  pa_next;

  seg_base_regs #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (seg_we),
    .wsel  (seg_wsel),
    .wdata (seg_wdata),
    .rsel  (req_sel),
    .rdata (sel_base)
  );

  seg_offset_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_add (
    .seg (sel_base),
    .off (req_off),
    .pa  (pa_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_valid <= 1'b0;
      pa_addr  <= '0;
    end else begin
      pa_valid <= req;
      if (req) pa_addr <= pa_next;
    end
  end

  // R5: valid follows the strobe by one cycle
  p_valid_follow_r5: assert property (@(posedge clk) disable iff (rst)
    req |=> pa_valid);
  p_valid_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !req |=> !pa_valid);
  // R5: address holds when idle
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !req |=> $stable(pa_addr));
  // R2: low bits below the shift come straight from the offset
  p_low_bits_r2: assert property (@(posedge clk) disable iff (rst)
    req |=> (pa_addr[SHIFT-1:0] == $past(req_off[SHIFT-1:0])));

endmodule

// File: tb/seg_phys_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_phys_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_wsel = 2'b00;
  logic [15:0] seg_wdata = 16'h0;
  logic        req = 1'b0;
  logic [1:0]  req_sel = 2'b00;
  logic [15:0] req_off = 16'h0;
  logic        pa_valid;
  logic [19:0] pa_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_phys_addr_gen u_seg_phys_addr_gen (
    .clk(clk), .rst(rst), .seg_we(seg_we), .seg_wsel(seg_wsel),
    .seg_wdata(seg_wdata), .req(req), .req_sel(req_sel), .req_off(req_off),
    .pa_valid(pa_valid), .pa_addr(pa_addr)
  );

  // Select codes: 00 extra, 01 code, 10 stack, 11 data
  // Vector fields: {sel[1:0], segment[15:0], offset[15:0], expected[19:0]}
  localparam logic [53:0] VEC [9] = '{
    {2'b01, 16'h2500, 16'h95F3, 20'h2E5F3},  // R2
    {2'b01, 16'h2500, 16'h0000, 20'h25000},  // R2
    {2'b01, 16'h2500, 16'hFFFF, 20'h34FFF},  // R2
    {2'b11, 16'h1000, 16'h5020, 20'h15020},  // R8
    {2'b10, 16'h1500, 16'h0020, 20'h15020},  // R8
    {2'b00, 16'h1502, 16'h0000, 20'h15020},  // R8
    {2'b11, 16'hFFFF, 16'hFFFF, 20'h0FFEF},  // R3
    {2'b10, 16'hF800, 16'h8000, 20'h00000},  // R3
    {2'b00, 16'hFFFF, 16'h0010, 20'h00000}   // R3
  };

  task automatic chk(input string tag, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] val);
    seg_we = 1'b1; seg_wsel = sel; seg_wdata = val;
    @(negedge clk);
    seg_we = 1'b0;
  endtask

  // Request; on return outputs show the registered result
  task automatic rq(input logic [1:0] sel, input logic [15:0] off);
    req = 1'b1; req_sel = sel; req_off = off;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [19:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid after reset", {19'h0, pa_valid}, 20'h0);
    chk("R1 addr after reset", pa_addr, 20'h0);
    rst = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rq(2'(s), 16'h1234);
      chk("R1 segment cleared", pa_addr, 20'h01234);
    end

    // Vector table
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][53:52], VEC[i][51:36]);
      rq(VEC[i][53:52], VEC[i][35:20]);
      chk("R2/R3/R8 vector valid", {19'h0, pa_valid}, 20'h1);
      chk("R2/R3/R8 vector addr", pa_addr, VEC[i][19:0]);
    end

    // R5: valid drops and address holds when idle
    held = pa_addr;
    @(negedge clk);
    chk("R5 valid low when idle", {19'h0, pa_valid}, 20'h0);
    chk("R5 addr held when idle", pa_addr, held);

    // R4: independent registers, encoding
    wr(2'b00, 16'h1111);
    wr(2'b01, 16'h2222);
    wr(2'b10, 16'h3333);
    wr(2'b11, 16'h4444);
    rq(2'b00, 16'h0000); chk("R4 extra sel 00", pa_addr, 20'h11110);
    rq(2'b01, 16'h0000); chk("R4 code sel 01", pa_addr, 20'h22220);
    rq(2'b10, 16'h0000); chk("R4 stack sel 10", pa_addr, 20'h33330);
    rq(2'b11, 16'h0000); chk("R4 data sel 11", pa_addr, 20'h44440);

    // R7: write to stack only
    wr(2'b10, 16'h0ABC);
    rq(2'b00, 16'h0001); chk("R7 extra kept", pa_addr, 20'h11111);
    rq(2'b01, 16'h0001); chk("R7 code kept", pa_addr, 20'h22221);
    rq(2'b11, 16'h0001); chk("R7 data kept", pa_addr, 20'h44441);
    rq(2'b10, 16'h0001); chk("R7 stack written", pa_addr, 20'h0ABC1);

    // R6: same-cycle write and request on code register
    seg_we = 1'b1; seg_wsel = 2'b01; seg_wdata = 16'hAAAA;
    req = 1'b1; req_sel = 2'b01; req_off = 16'h0005;
    @(negedge clk);
    seg_we = 1'b0; req = 1'b0;
    chk("R6 old base used", pa_addr, 20'h22225);
    rq(2'b01, 16'h0005);
    chk("R6 new base afterwards", pa_addr, 20'hAAAA5);

    // R1: mid-run reset
    req = 1'b1; req_sel = 2'b11; req_off = 16'h0007;
    rst = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R1 reset overrides request valid", {19'h0, pa_valid}, 20'h0);
    chk("R1 reset clears addr", pa_addr, 20'h0);
    rst = 1'b0;
    rq(2'b11, 16'h0007);
    chk("R1 data cleared by reset", pa_addr, 20'h00007);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule